// File: doc/BRIEF.md
# Paged Byte-Write Memory Controller

This block models, one clock at a time, the control logic of a byte-alterable parallel non-volatile memory. The host drives active-low chip enable, output enable and write enable, a 16-bit address and a data byte. The data bus is split into an input byte, an output byte and an output-enable flag, which together stand for one bidirectional bus. Written bytes go into a page buffer. The buffer flushes into the storage array when the host stops loading bytes for longer than a byte-load window.

While the flush runs, no write is accepted. Reads return a status byte instead of stored data: a polling bit holds the inverse of the last loaded byte's top bit, and a toggle bit flips on every new read. A host can poll either bit to find out when the programming cycle has finished. All time limits are counted in clock cycles and set by parameters. The storage array is a plain synchronous memory inside the block.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: `dq_oe` is 1 exactly while `ce_n` and `oe_n` are both 0. In every other pin state it is 0.
- R2: A read outside programming puts the array byte at `addr[ARRAY_AW-1:0]` on `dq_o` one clock after the pins are sampled. The array holds 2^ARRAY_AW bytes (1024 by default), so address bits above ARRAY_AW alias.
- R3: A write cycle is any span where `ce_n` and `we_n` are 0 while `oe_n` is 1, whether `we_n` or `ce_n` falls last. The address is taken when the cycle begins and the data when it ends, so an address change in mid-cycle has no effect.
- R4: Bytes loaded within one page sit at offset `addr[6:0]` and are programmed together. A repeated offset keeps the later byte.
- R5: A byte load whose `addr[15:7]` differs from the first byte of the current page is dropped and does not restart the window.
- R6: Each accepted load restarts a window of WIN_CYC cycles. Loads spaced closer than that join the same page, and reads during loading still return array data.
- R7: Programming starts when the window expires with no write cycle on the bus, and lasts PROG_CYC cycles. Afterwards the array holds the page, the buffer is empty, and a new page may use any page address.
- R8: During programming, bit 7 of read data is the inverse of bit 7 of the last accepted byte, for any address. Bits 5:0 read 0.
- R9: During programming, bit 6 flips at the start of each read, reading 1 on the first read. Once programming ends, reads of one address return equal data.
- R10: A write cycle that begins during programming changes neither the buffer nor the array.
- R11: After reset, `dq_o` is 0 and holds its value while no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Data bus as driven by the host |
| dq_o | output | DATA_W | Data bus as driven by the block |
| dq_oe | output | 1 | Block drives the data bus |

## Verification
A table of page loads mixes write cycles controlled by write enable, cycles controlled by chip enable, and cycles whose address moves in mid-cycle. The table also includes a repeated offset, so read-back separates the right capture edge and the last-write-wins rule from simpler faults. During loading, a stray byte for another page and a load placed just inside the window show whether the page filter and the window restart work. While programming runs, consecutive status reads and a rejected write tell the polling bit, the toggle bit and the write lockout apart from ordinary array data.

// File: rtl/epc_pkg.sv
package epc_pkg;
   typedef enum logic [1:0] {
      EPC_IDLE = 2'd0,
      EPC_LOAD = 2'd1,
      EPC_PROG = 2'd2
   } epc_state_e;
endpackage

// File: rtl/epc_bus_sense.sv
// Samples the control pins and marks the edges of write and read cycles.
module epc_bus_sense #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_start,
   output logic              wr_end,
   output logic              wr_busy,
   output logic              rd_now,
   output logic              rd_start,
   output logic [ADDR_W-1:0] cap_addr
);
   logic wr_now, wr_q, rd_q;

   assign wr_now   = ~ce_n & ~we_n & oe_n;
   assign rd_now   = ~ce_n & ~oe_n;
   assign wr_start = wr_now & ~wr_q;   // later of the two falling edges
   assign wr_end   = ~wr_now & wr_q;   // earlier of the two rising edges
   assign wr_busy  = wr_now | wr_q;
   assign rd_start = rd_now & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         rd_q     <= 1'b0;
         cap_addr <= '0;
      end else begin
         wr_q <= wr_now;
         rd_q <= rd_now;
         if (wr_start) cap_addr <= addr;
      end
   end
endmodule

// File: rtl/epc_page_buf.sv
// Page buffer: one data register and one valid flag per byte offset.
module epc_page_buf #(
   parameter int PAGE_BYTES = 128,
   parameter int DATA_W     = 8,
   localparam int PAGE_AW   = $clog2(PAGE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               we,
   input  logic [PAGE_AW-1:0] w_off,
   input  logic [DATA_W-1:0]  w_data,
   input  logic [PAGE_AW-1:0] r_off,
   output logic               r_valid,
   output logic [DATA_W-1:0]  r_data
);
   logic [PAGE_BYTES-1:0] val_w;
   logic [DATA_W-1:0]     dat_w [PAGE_BYTES];

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_ent
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (we && (w_off == PAGE_AW'(i))) begin
            v_q <= 1'b1;
            d_q <= w_data;
         end
      end
      assign val_w[i] = v_q;
      assign dat_w[i] = d_q;
   end

   assign r_valid = val_w[r_off];
   assign r_data  = dat_w[r_off];
endmodule

// File: rtl/epc_prog_seq.sv
// Load / window / programming sequencer with the status toggle bit.
module epc_prog_seq
   import epc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 128,
   parameter int WIN_CYC    = 64,
   parameter int PROG_CYC   = 200,
   localparam int PAGE_AW   = $clog2(PAGE_BYTES),
   localparam int TAG_W     = ADDR_W - PAGE_AW,
   localparam int WC_W      = $clog2(WIN_CYC + 1),
   localparam int PC_W      = $clog2(PROG_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_end,
   input  logic              wr_busy,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              buf_we,
   output logic              buf_clr,
   output logic              prog_busy,
   output logic [PC_W-1:0]   prog_idx,
   output logic [TAG_W-1:0]  tag_q,
   output logic              last7,
   output logic              tgl_nx
);
   epc_state_e       st_q;
   logic             ld_ok_q, start_ok, win_done, prog_done, tgl_q;
   logic [WC_W-1:0]  win_q;
   logic [PC_W-1:0]  pcnt_q;

   assign start_ok  = wr_start && (st_q != EPC_PROG) &&
                      ((st_q == EPC_IDLE) || (addr[ADDR_W-1:PAGE_AW] == tag_q));
   assign win_done  = (st_q == EPC_LOAD) && (win_q >= WC_W'(WIN_CYC - 1)) && !wr_busy;
   assign prog_done = (st_q == EPC_PROG) && (pcnt_q == PC_W'(PROG_CYC - 1));
   assign buf_we    = wr_end & ld_ok_q;
   assign buf_clr   = prog_done;
   assign prog_busy = (st_q == EPC_PROG);
   assign prog_idx  = pcnt_q;
   assign tgl_nx    = tgl_q ^ (rd_start & prog_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= EPC_IDLE;
         ld_ok_q <= 1'b0;
         tag_q   <= '0;
         win_q   <= '0;
         pcnt_q  <= '0;
         last7   <= 1'b0;
         tgl_q   <= 1'b0;
      end else begin
         if (wr_start) ld_ok_q <= start_ok;
         if (start_ok) begin
            tag_q <= addr[ADDR_W-1:PAGE_AW];
            win_q <= '0;
         end else if ((st_q == EPC_LOAD) && (win_q < WC_W'(WIN_CYC - 1))) begin
            win_q <= win_q + 1'b1;
         end
         if (buf_we) last7 <= din[DATA_W-1];
         tgl_q <= tgl_nx;
         unique case (st_q)
            EPC_IDLE: if (start_ok) st_q <= EPC_LOAD;
            EPC_LOAD: if (win_done) begin
               st_q   <= EPC_PROG;
               pcnt_q <= '0;
               tgl_q  <= 1'b0;
            end
            EPC_PROG: begin
               pcnt_q <= pcnt_q + 1'b1;
               if (prog_done) st_q <= EPC_IDLE;
            end
            default: st_q <= EPC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
   import epc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 128,
   parameter int ARRAY_AW   = 10,
   parameter int WIN_CYC    = 64,
   parameter int PROG_CYC   = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);
   localparam int TAG_W   = ADDR_W - PAGE_AW;
   localparam int PC_W    = $clog2(PROG_CYC + 1);
   localparam int DEPTH   = 2 ** ARRAY_AW;

   if (PAGE_BYTES != (2 ** PAGE_AW)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PROG_CYC < PAGE_BYTES) begin : g_bad_prog
      $error("PROG_CYC must cover one cycle per page byte");
   end
   if ((ARRAY_AW < PAGE_AW) || (ARRAY_AW > ADDR_W)) begin : g_bad_array
      $error("ARRAY_AW out of range");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold the status bits");
   end

   logic              wr_start, wr_end, wr_busy, rd_now, rd_start;
   logic [ADDR_W-1:0] cap_addr;
   logic              buf_we, buf_clr, prog_busy, last7, tgl_nx;
   logic [PC_W-1:0]   prog_idx;
   logic [TAG_W-1:0]  tag_q;
   logic              buf_rvalid;
   logic [DATA_W-1:0] buf_rdata;
   logic              arr_we, ld_tag_ok;
   logic [ADDR_W-1:0] arr_full;
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] status_b, dq_q;

   epc_bus_sense #(.ADDR_W(ADDR_W)) u_sense (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wr_start(wr_start), .wr_end(wr_end), .wr_busy(wr_busy),
      .rd_now(rd_now), .rd_start(rd_start), .cap_addr(cap_addr)
   );

   epc_prog_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
      .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
      .wr_busy(wr_busy), .rd_start(rd_start), .addr(addr), .din(dq_i),
      .buf_we(buf_we), .buf_clr(buf_clr), .prog_busy(prog_busy),
      .prog_idx(prog_idx), .tag_q(tag_q), .last7(last7), .tgl_nx(tgl_nx)
   );

   epc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
      .w_off(cap_addr[PAGE_AW-1:0]), .w_data(dq_i),
      .r_off(prog_idx[PAGE_AW-1:0]), .r_valid(buf_rvalid), .r_data(buf_rdata)
   );

   assign ld_tag_ok = (cap_addr[ADDR_W-1:PAGE_AW] == tag_q);
   assign arr_full  = {tag_q, prog_idx[PAGE_AW-1:0]};
   assign arr_we    = prog_busy && (prog_idx < PC_W'(PAGE_BYTES)) && buf_rvalid;
   assign status_b  = {~last7, tgl_nx, {(DATA_W-2){1'b0}}};

   always_ff @(posedge clk) begin
      if (arr_we) mem_q[arr_full[ARRAY_AW-1:0]] <= buf_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_q <= '0;
      end else if (rd_now) begin
         dq_q <= prog_busy ? status_b : mem_q[addr[ARRAY_AW-1:0]];
      end
   end

   assign dq_o  = dq_q;
   assign dq_oe = rd_now;
endmodule

// File: rtl/epc_chk.sv
module epc_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_o,
   input logic              prog_busy,
   input logic              buf_we,
   input logic              ld_tag_ok,
   input logic              last7,
   input logic              wr_busy
);
   // R1
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !dq_oe);

   // R10
   no_load_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |-> !buf_we);

   // R5
   page_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> ld_tag_ok);

   // R8
   poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(prog_busy) && $past(!ce_n && !oe_n)) |-> (dq_o[DATA_W-1] == !$past(last7)));

   // R7
   start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_busy) |-> !$past(wr_busy));
endmodule

bind eeprom_page_ctrl epc_chk #(.DATA_W(DATA_W)) u_epc_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_oe(dq_oe),
   .dq_o(dq_o), .prog_busy(prog_busy), .buf_we(buf_we),
   .ld_tag_ok(ld_tag_ok), .last7(last7), .wr_busy(wr_busy)
);

// File: tb/tb_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_page_ctrl;
   localparam int WIN  = 64;
   localparam int PROG = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  dq_i = '0;
   logic [7:0]  dq_o;
   logic        dq_oe;
   int total = 0;
   int bad   = 0;

   eeprom_page_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   always #2 clk = ~clk;

   // {address, data, mode, expected read-back}; mode 0 = write enable last,
   // 1 = chip enable controls the cycle, 2 = address moves in mid-cycle
   localparam logic [33:0] VEC [6] = '{
      {16'h0100, 8'hA5, 2'd0, 8'hA5},
      {16'h0105, 8'h10, 2'd0, 8'h77},
      {16'h017F, 8'hFF, 2'd1, 8'hFF},
      {16'h0140, 8'h00, 2'd2, 8'h00},
      {16'h0105, 8'h77, 2'd0, 8'h77},
      {16'h0110, 8'h96, 2'd1, 8'h96}
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%02h exp=%02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input int mode);
      @(negedge clk);
      addr = a;
      dq_i = d;
      if (mode == 1) begin
         we_n = 1'b0;
         @(negedge clk) ce_n = 1'b0;
         @(negedge clk) ce_n = 1'b1;
         @(negedge clk) we_n = 1'b1;
      end else begin
         ce_n = 1'b0;
         we_n = 1'b0;
         @(negedge clk);
         if (mode == 2) begin
            addr = a ^ 16'h0001;
            @(negedge clk);
         end
         we_n = 1'b1;
         ce_n = 1'b1;
      end
      @(negedge clk);
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a;
      ce_n = 1'b0;
      oe_n = 1'b0;
      @(posedge clk);
      #1;
      d  = dq_o;
      oe = dq_oe;
      @(negedge clk);
      ce_n = 1'b1;
      oe_n = 1'b1;
      @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       oe;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 dq_o after reset", dq_o, 8'h00);
      chk("R1 idle bus undriven", {7'd0, dq_oe}, 8'h00);
      @(negedge clk) rst_n = 1'b1;

      // R1: only one of the two enables low
      @(negedge clk);
      ce_n = 1'b0;
      #1 chk("R1 ce only", {7'd0, dq_oe}, 8'h00);
      ce_n = 1'b1;
      oe_n = 1'b0;
      #1 chk("R1 oe only", {7'd0, dq_oe}, 8'h00);
      oe_n = 1'b1;
      #1 chk("R11 dq_o holds without read", dq_o, 8'h00);

      // R7: first page, then full programming time
      wr(16'h0380, 8'h11, 0);
      repeat (WIN + PROG + 20) @(posedge clk);
      rd(16'h0380, d, oe);
      chk("R7 first page programmed", d, 8'h11);
      chk("R1 read drives bus", {7'd0, oe}, 8'h01);
      rd(16'h0780, d, oe);
      chk("R2 address alias", d, 8'h11);

      // R3 R4: page of table vectors
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][33:18], VEC[i][17:10], int'(VEC[i][9:8]));
      end
      // R6: next load just inside the window
      repeat (WIN - 8) @(posedge clk);
      wr(16'h0150, 8'h3C, 0);
      rd(16'h0380, d, oe);
      chk("R6 array data while loading", d, 8'h11);
      // R5: byte for another page dropped
      wr(16'h0380, 8'hEE, 0);

      // R8 R9: status during programming
      repeat (WIN + 10) @(posedge clk);
      rd(16'h0100, d, oe);
      chk("R8 R9 first status read", d, 8'hC0);
      rd(16'h0123, d, oe);
      chk("R9 second status read", d, 8'h80);
      // R10: write attempt during programming
      wr(16'h0100, 8'h5A, 0);
      rd(16'h0100, d, oe);
      chk("R8 third status read", d, 8'hC0);

      repeat (PROG + 20) @(posedge clk);
      for (int i = 0; i < 6; i++) begin
         rd(VEC[i][33:18], d, oe);
         chk($sformatf("R3 R4 readback %04h", VEC[i][33:18]), d, VEC[i][7:0]);
      end
      rd(16'h0150, d, oe);
      chk("R6 spaced load joined page", d, 8'h3C);
      rd(16'h0380, d, oe);
      chk("R5 other page unchanged", d, 8'h11);
      rd(16'h0100, d, oe);
      chk("R10 write in programming ignored", d, 8'hA5);
      rd(16'h0110, d, oe);
      chk("R9 toggling stopped a", d, 8'h96);
      rd(16'h0110, d, oe);
      chk("R9 toggling stopped b", d, 8'h96);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule